// File: doc/BRIEF.md
# Clock and Low-Power Mode Controller

This block is the mode sequencer of a small microcontroller. It moves the chip between running on the main oscillator clock and running on the PLL clock. It also takes the chip into and out of three kinds of standby: sleep, timebase-only and full stop. Its inputs are the control-register bits software writes, the reset sources, the interrupt request line and two stabilization flags from the timebase timer. From these it drives the oscillator and PLL enables, the clock source select, the CPU and peripheral clock gates, the pin hold and high-impedance controls, and a mode code.

The clock select bit works inverted: a 1 selects the main clock, a 0 asks for the PLL. A switch to the PLL waits until the PLL reports that it is stable, and the CPU keeps running on the main clock during that wait. The place a reset sends the controller depends on the source of the reset. A watchdog reset always lands in main-clock run. An external or software reset taken while the chip runs from the PLL lands back in PLL run. Every standby mode ends on an interrupt or a reset, and the controller then pulses a clear strobe for the sleep and stop request bits.

Top module: `clkpwr_ctrl`

## Requirements
- R1: While `rst_n` is low, and afterwards until `osc_stable` is 1 with no reset source active, the mode code is 0 (power-on wait). In mode 0 `osc_en`=1 and both clock gates are 0. Mode 1 (main run) follows on the next clock edge.
- R2: In main run with `clk_sel_main`=0, the next mode is 2 (PLL wait), with `pll_en`=1, `clk_src_pll`=0 and the CPU clock running. Mode 2 moves to mode 3 (PLL run, `clk_src_pll`=1) on the edge where `pll_stable`=1. It returns to mode 1 if `clk_sel_main` is back at 1.
- R3: In PLL run, `clk_sel_main`=1 leads to mode 1 on the next edge, with `pll_en`=0.
- R4: An external or software reset (`ext_rst`, `sw_rst`) taken in mode 3, 5 or 6 leads to mode 9 (reset hold), with `pll_en` kept at 1. Mode 3 follows once no reset source is active and both stable flags are 1.
- R5: A watchdog reset in any mode other than 0 leads to mode 9 with `pll_en`=0. Mode 1 follows once no reset is active and `osc_stable`=1. Any reset taken in modes 1, 2, 4, 7 or 8 resumes to mode 1 in the same way.
- R6: A sleep request leads from mode 1 to mode 4 (main sleep) and from mode 3 to mode 5 (PLL sleep). In both sleep modes `cpu_clk_en`=0 while `per_clk_en`=1 and `osc_en`=1. In mode 5 the PLL stays selected.
- R7: A stop request in mode 3 (PLL run, so `clk_sel_main`=0) leads to mode 6 (timebase only). In mode 6 `osc_en`=1 and `pll_en`, `cpu_clk_en` and `per_clk_en` are all 0.
- R8: A stop request in mode 1 (main run) leads to mode 7 (stop). In mode 7 `osc_en`=0 and all clock gates are 0.
- R9: In modes 6, 7 and 8, `pin_hold`=!`pin_float_sel` and `pin_hiz`=`pin_float_sel`. In every other mode both are 0.
- R10: An interrupt releases standby as follows: mode 4 goes to mode 1, mode 5 to mode 3, mode 6 to mode 2, and mode 7 to mode 8 (oscillator restart, `osc_en`=1). Mode 8 goes to mode 1 on the edge where `osc_stable`=1.
- R11: In a run mode, a clock-select change takes priority over a stop request, and a stop request takes priority over a sleep request.
- R12: `req_clr` is 1 exactly in cycles where the mode is 4 to 7 and `irq` or a reset source is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst | input | 1 | External reset request |
| sw_rst | input | 1 | Software reset request |
| wdt_rst | input | 1 | Watchdog reset request |
| irq | input | 1 | Interrupt request, ends standby |
| clk_sel_main | input | 1 | 1 selects the main clock, 0 requests the PLL |
| sleep_req | input | 1 | Sleep request bit |
| stop_req | input | 1 | Stop request bit |
| pin_float_sel | input | 1 | Standby pin policy: 0 hold, 1 high-impedance |
| osc_stable | input | 1 | Oscillator stabilization interval done |
| pll_stable | input | 1 | PLL stabilization interval done |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| clk_src_pll | output | 1 | System clock taken from the PLL |
| cpu_clk_en | output | 1 | CPU clock gate |
| per_clk_en | output | 1 | Peripheral clock gate |
| pin_hold | output | 1 | Hold pins at their last state |
| pin_hiz | output | 1 | Put pins in high-impedance |
| req_clr | output | 1 | Clear strobe for the sleep and stop bits |
| mode_code | output | 4 | Current mode code |

## Verification
The mode code, and every enable and gate derived from it, changes one clock edge after the inputs that cause the change. `pin_hold`, `pin_hiz` and `req_clr` also depend on the live policy, interrupt and reset inputs, so they answer in the same cycle those inputs are applied. The bench changes its inputs on the falling edge and keeps a reference model. The model advances on each rising edge using the same held inputs, and all outputs are compared at the next falling edge. The comparison uses the model's new mode together with the inputs still applied. Directed sequences walk every transition and priority case; a seeded random phase then mixes resets, interrupts and requests.

// File: rtl/clkpwr_pkg.sv
package clkpwr_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    M_POR     = 4'd0,
    M_MAIN    = 4'd1,
    M_PLLWAIT = 4'd2,
    M_PLL     = 4'd3,
    M_MSLEEP  = 4'd4,
    M_PSLEEP  = 4'd5,
    M_TBT     = 4'd6,
    M_STOP    = 4'd7,
    M_OSCWAIT = 4'd8,
    M_RSTHOLD = 4'd9
  } mode_e;

  typedef struct packed {
    logic osc_en;
    logic pll_en;
    logic sel_pll;
    logic cpu_en;
    logic per_en;
    logic standby;
  } ctl_t;

  function automatic logic is_lowpower(mode_e m);
    return (m == M_MSLEEP) || (m == M_PSLEEP) || (m == M_TBT) || (m == M_STOP);
  endfunction

  function automatic logic is_pll_domain(mode_e m);
    return (m == M_PLL) || (m == M_PSLEEP) || (m == M_TBT);
  endfunction
endpackage

// File: rtl/clkpwr_next.sv
module clkpwr_next
  import clkpwr_pkg::*;
(
  input  mode_e cur,
  input  logic  resume_pll,
  input  logic  sel_main,
  input  logic  slp,
  input  logic  stp,
  input  logic  irq,
  input  logic  ext_sw_rst,
  input  logic  wdt_rst,
  input  logic  osc_ok,
  input  logic  pll_ok,
  output mode_e nxt,
  output logic  nxt_resume,
  output logic  release_evt
);
  logic any_rst;
  assign any_rst = ext_sw_rst | wdt_rst;
  assign release_evt = is_lowpower(cur) & (irq | any_rst);

  // Run-state choice: clock switch first, then stop, then sleep.
  function automatic mode_e run_pick(mode_e here, logic want_main, logic s, logic p);
    mode_e r = here;
    if (here == M_MAIN) begin
      if (!want_main) r = M_PLLWAIT;
      else if (p)     r = M_STOP;
      else if (s)     r = M_MSLEEP;
    end else begin
      if (want_main)  r = M_MAIN;
      else if (p)     r = M_TBT;
      else if (s)     r = M_PSLEEP;
    end
    return r;
  endfunction

  always_comb begin
    nxt = cur;
    nxt_resume = resume_pll;
    if (cur == M_POR) begin
      if (osc_ok && !any_rst) nxt = M_MAIN;
      nxt_resume = 1'b0;
    end else if (any_rst) begin
      nxt = M_RSTHOLD;
      if (wdt_rst)              nxt_resume = 1'b0;
      else if (cur != M_RSTHOLD) nxt_resume = is_pll_domain(cur);
    end else begin
      unique case (cur)
        M_MAIN, M_PLL: nxt = run_pick(cur, sel_main, slp, stp);
        M_PLLWAIT: begin
          if (sel_main)    nxt = M_MAIN;
          else if (pll_ok) nxt = M_PLL;
        end
        M_MSLEEP:  if (irq) nxt = M_MAIN;
        M_PSLEEP:  if (irq) nxt = M_PLL;
        M_TBT:     if (irq) nxt = M_PLLWAIT;
        M_STOP:    if (irq) nxt = M_OSCWAIT;
        M_OSCWAIT: if (osc_ok) nxt = M_MAIN;
        M_RSTHOLD: if (osc_ok && (!resume_pll || pll_ok)) nxt = resume_pll ? M_PLL : M_MAIN;
        default:   nxt = M_POR;
      endcase
    end
  end
endmodule

// File: rtl/clkpwr_decode.sv
module clkpwr_decode
  import clkpwr_pkg::*;
(
  input  mode_e mode,
  input  logic  resume_pll,
  input  logic  float_sel,
  output ctl_t  ctl,
  output logic  pin_hold,
  output logic  pin_hiz
);
  function automatic ctl_t mode_ctl(mode_e m, logic keep_pll);
    ctl_t c = '0;
    c.osc_en = (m != M_STOP);
    unique case (m)
      M_MAIN:    begin c.cpu_en = 1'b1; c.per_en = 1'b1; end
      M_PLLWAIT: begin c.pll_en = 1'b1; c.cpu_en = 1'b1; c.per_en = 1'b1; end
      M_PLL:     begin c.pll_en = 1'b1; c.sel_pll = 1'b1; c.cpu_en = 1'b1; c.per_en = 1'b1; end
      M_MSLEEP:  c.per_en = 1'b1;
      M_PSLEEP:  begin c.pll_en = 1'b1; c.sel_pll = 1'b1; c.per_en = 1'b1; end
      M_TBT, M_STOP, M_OSCWAIT: c.standby = 1'b1;
      M_RSTHOLD: c.pll_en = keep_pll;
      default:   ;
    endcase
    return c;
  endfunction

  assign ctl      = mode_ctl(mode, resume_pll);
  assign pin_hold = ctl.standby & ~float_sel;
  assign pin_hiz  = ctl.standby & float_sel;
endmodule

// File: rtl/clkpwr_ctrl.sv
module clkpwr_ctrl
  import clkpwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_rst,
  input  logic              sw_rst,
  input  logic              wdt_rst,
  input  logic              irq,
  input  logic              clk_sel_main,
  input  logic              sleep_req,
  input  logic              stop_req,
  input  logic              pin_float_sel,
  input  logic              osc_stable,
  input  logic              pll_stable,
  output logic              osc_en,
  output logic              pll_en,
  output logic              clk_src_pll,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              pin_hold,
  output logic              pin_hiz,
  output logic              req_clr,
  output logic [MODE_W-1:0] mode_code
);
  mode_e mode_q, mode_d;
  logic  resume_q, resume_d;
  logic  release_evt;
  logic  any_rst;
  ctl_t  ctl;

  assign any_rst = ext_rst | sw_rst | wdt_rst;

  clkpwr_next u_next (
    .cur(mode_q), .resume_pll(resume_q), .sel_main(clk_sel_main),
    .slp(sleep_req), .stp(stop_req), .irq(irq),
    .ext_sw_rst(ext_rst | sw_rst), .wdt_rst(wdt_rst),
    .osc_ok(osc_stable), .pll_ok(pll_stable),
    .nxt(mode_d), .nxt_resume(resume_d), .release_evt(release_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_POR;
      resume_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      resume_q <= resume_d;
    end
  end

  clkpwr_decode u_dec (
    .mode(mode_q), .resume_pll(resume_q), .float_sel(pin_float_sel),
    .ctl(ctl), .pin_hold(pin_hold), .pin_hiz(pin_hiz)
  );

  assign osc_en      = ctl.osc_en;
  assign pll_en      = ctl.pll_en;
  assign clk_src_pll = ctl.sel_pll;
  assign cpu_clk_en  = ctl.cpu_en;
  assign per_clk_en  = ctl.per_en;
  assign req_clr     = release_evt;
  assign mode_code   = mode_q;
endmodule

// File: rtl/clkpwr_ctrl_chk.sv
module clkpwr_ctrl_chk
  import clkpwr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wdt_rst,
  input logic              any_rst,
  input logic              clk_sel_main,
  input logic              release_evt,
  input logic              osc_en,
  input logic              pll_en,
  input logic              clk_src_pll,
  input logic              cpu_clk_en,
  input logic              per_clk_en,
  input logic              pin_hold,
  input logic              pin_hiz,
  input logic [MODE_W-1:0] mode_code
);
  AST_POR_CPU_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 4'd0) |-> (!cpu_clk_en && osc_en)); // R1
  AST_PLL_SEL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    clk_src_pll |-> pll_en); // R2
  AST_PLL_TO_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 4'd3 && clk_sel_main && !any_rst) |=> (mode_code == 4'd1 && !pll_en)); // R3
  AST_WDT_TO_MAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_rst && mode_code != 4'd0) |=> (mode_code == 4'd9 && !pll_en)); // R5
  AST_SLEEP_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 4'd4 || mode_code == 4'd5) |-> (per_clk_en && !cpu_clk_en)); // R6
  AST_TBT_OSC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 4'd6) |-> (osc_en && !per_clk_en && !pll_en)); // R7
  AST_STOP_OSC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 4'd7) |-> !osc_en); // R8
  AST_PINS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(pin_hold && pin_hiz)); // R9
  AST_RELEASE_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> !(mode_code >= 4'd4 && mode_code <= 4'd7)); // R12
endmodule

bind clkpwr_ctrl clkpwr_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst), .any_rst(any_rst),
  .clk_sel_main(clk_sel_main), .release_evt(release_evt),
  .osc_en(osc_en), .pll_en(pll_en), .clk_src_pll(clk_src_pll),
  .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
  .pin_hold(pin_hold), .pin_hiz(pin_hiz), .mode_code(mode_code)
);

// File: tb/clkpwr_ctrl_test.sv
module clkpwr_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_rst = 0, sw_rst = 0, wdt_rst = 0, irq = 0;
  logic clk_sel_main = 1, sleep_req = 0, stop_req = 0, pin_float_sel = 0;
  logic osc_stable = 0, pll_stable = 0;
  logic osc_en, pll_en, clk_src_pll, cpu_clk_en, per_clk_en, pin_hold, pin_hiz, req_clr;
  logic [3:0] mode_code;

  int checks = 0;
  int errors = 0;
  int m_mode = 0;
  bit m_res = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkpwr_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .sw_rst(sw_rst), .wdt_rst(wdt_rst),
    .irq(irq), .clk_sel_main(clk_sel_main), .sleep_req(sleep_req), .stop_req(stop_req),
    .pin_float_sel(pin_float_sel), .osc_stable(osc_stable), .pll_stable(pll_stable),
    .osc_en(osc_en), .pll_en(pll_en), .clk_src_pll(clk_src_pll), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .pin_hold(pin_hold), .pin_hiz(pin_hiz), .req_clr(req_clr),
    .mode_code(mode_code)
  );

  function automatic bit standby_mode(int m);
    return m == 6 || m == 7 || m == 8;
  endfunction

  function automatic bit lp_mode(int m);
    return m >= 4 && m <= 7;
  endfunction

  // Reference next mode, written from the requirement list.
  function automatic int ref_mode(int m, bit res);
    bit r = ext_rst | sw_rst | wdt_rst;
    if (!rst_n) return 0;
    if (m == 0) return (osc_stable && !r) ? 1 : 0;
    if (r) return 9;
    case (m)
      1: return !clk_sel_main ? 2 : stop_req ? 7 : sleep_req ? 4 : 1;
      2: return clk_sel_main ? 1 : pll_stable ? 3 : 2;
      3: return clk_sel_main ? 1 : stop_req ? 6 : sleep_req ? 5 : 3;
      4: return irq ? 1 : 4;
      5: return irq ? 3 : 5;
      6: return irq ? 2 : 6;
      7: return irq ? 8 : 7;
      8: return osc_stable ? 1 : 8;
      9: begin
        if (!osc_stable) return 9;
        if (res) return pll_stable ? 3 : 9;
        return 1;
      end
      default: return 0;
    endcase
  endfunction

  function automatic bit ref_res(int m, bit res);
    if (!rst_n || m == 0) return 0;
    if (wdt_rst) return 0;
    if (ext_rst | sw_rst) return (m == 9) ? res : (m == 3 || m == 5 || m == 6);
    return res;
  endfunction

  // {osc, pll, sel, cpu, per}
  function automatic logic [4:0] ref_clk(int m, bit res);
    case (m)
      0: return 5'b10000;
      1: return 5'b10011;
      2: return 5'b11011;
      3: return 5'b11111;
      4: return 5'b10001;
      5: return 5'b11101;
      6: return 5'b10000;
      7: return 5'b00000;
      8: return 5'b10000;
      9: return {1'b1, res, 3'b000};
      default: return 5'b00000;
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    int nm;
    bit nr;
    @(posedge clk);
    nm = ref_mode(m_mode, m_res);
    nr = ref_res(m_mode, m_res);
    m_mode = nm;
    m_res = nr;
    @(negedge clk);
    chk("R11 mode sequence", {4'd0, mode_code}, m_mode[7:0]);
    chk("R2 clock enables", {5'd0, osc_en, pll_en, clk_src_pll}, {5'd0, ref_clk(m_mode, m_res)[4:2]});
    chk("R6 clock gates", {6'd0, cpu_clk_en, per_clk_en}, {6'd0, ref_clk(m_mode, m_res)[1:0]});
    chk("R9 pin controls", {6'd0, pin_hold, pin_hiz},
        standby_mode(m_mode) ? {6'd0, !pin_float_sel, pin_float_sel} : 8'd0);
    chk("R12 clear strobe", {7'd0, req_clr},
        {7'd0, lp_mode(m_mode) && (irq | ext_rst | sw_rst | wdt_rst)});
  endtask

  task automatic cycn(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired, run hung");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: power-on wait
    cycn(3);
    chk("R1 reset mode", {4'd0, mode_code}, 8'd0);
    chk("R1 reset gates", {5'd0, osc_en, cpu_clk_en, per_clk_en}, 8'b100);
    @(negedge clk); rst_n = 1;
    cycn(3);
    chk("R1 waits for osc", {4'd0, mode_code}, 8'd0);
    osc_stable = 1;
    cyc();
    chk("R1 main run entered", {4'd0, mode_code}, 8'd1);
    // R2: switch to PLL
    clk_sel_main = 0;
    cyc();
    chk("R2 pll wait", {4'd0, mode_code}, 8'd2);
    chk("R2 cpu on main clock", {6'd0, clk_src_pll, cpu_clk_en}, 8'b01);
    cycn(2);
    pll_stable = 1;
    cyc();
    chk("R2 pll run", {4'd0, mode_code}, 8'd3);
    chk("R2 pll selected", {7'd0, clk_src_pll}, 8'd1);
    // R4: external reset in PLL run
    ext_rst = 1;
    cyc();
    chk("R4 reset hold", {4'd0, mode_code}, 8'd9);
    chk("R4 pll kept", {7'd0, pll_en}, 8'd1);
    ext_rst = 0;
    cyc();
    chk("R4 back to pll run", {4'd0, mode_code}, 8'd3);
    // R11 and R7: stop wins over sleep
    sleep_req = 1; stop_req = 1; pin_float_sel = 1;
    cyc();
    chk("R11 stop beats sleep", {4'd0, mode_code}, 8'd6);
    chk("R7 timebase enables", {5'd0, osc_en, pll_en, per_clk_en}, 8'b100);
    chk("R9 high-z", {6'd0, pin_hold, pin_hiz}, 8'b01);
    pin_float_sel = 0;
    #1;
    chk("R9 hold", {6'd0, pin_hold, pin_hiz}, 8'b10);
    irq = 1;
    #1;
    chk("R12 strobe on release", {7'd0, req_clr}, 8'd1);
    cyc();
    chk("R10 timebase to pll wait", {4'd0, mode_code}, 8'd2);
    irq = 0; sleep_req = 0; stop_req = 0;
    cyc();
    chk("R10 pll run again", {4'd0, mode_code}, 8'd3);
    // R5: watchdog in PLL run
    wdt_rst = 1;
    cyc();
    chk("R5 wdt hold", {4'd0, mode_code, 3'd0, pll_en}, {4'd0, 4'd9, 4'd0});
    wdt_rst = 0;
    cyc();
    chk("R5 wdt to main", {4'd0, mode_code}, 8'd1);
    // R6: main sleep
    clk_sel_main = 1; sleep_req = 1;
    cyc();
    chk("R6 main sleep", {4'd0, mode_code}, 8'd4);
    irq = 1; cyc();
    chk("R10 main sleep release", {4'd0, mode_code}, 8'd1);
    irq = 0; sleep_req = 0;
    // R8: stop from main
    stop_req = 1;
    cyc();
    chk("R8 stop mode", {4'd0, mode_code}, 8'd7);
    chk("R8 osc off", {7'd0, osc_en}, 8'd0);
    osc_stable = 0; irq = 1;
    cyc();
    irq = 0; stop_req = 0;
    chk("R10 osc restart", {4'd0, mode_code, 3'd0, osc_en}, {4'd0, 4'd8, 4'd1});
    cycn(2);
    osc_stable = 1;
    cyc();
    chk("R10 stop release done", {4'd0, mode_code}, 8'd1);
    // R11: clock switch beats stop; R3: back to main
    clk_sel_main = 0; stop_req = 1;
    cyc();
    chk("R11 switch beats stop", {4'd0, mode_code}, 8'd2);
    stop_req = 0;
    cyc();
    clk_sel_main = 1;
    cyc();
    chk("R3 pll to main", {4'd0, mode_code, 3'd0, pll_en}, {4'd0, 4'd1, 4'd0});
    // R4 from PLL sleep with software reset
    clk_sel_main = 0; cycn(2);
    sleep_req = 1; cyc();
    chk("R6 pll sleep", {4'd0, mode_code}, 8'd5);
    sw_rst = 1; cyc();
    sw_rst = 0; sleep_req = 0; cyc();
    chk("R4 sw reset to pll", {4'd0, mode_code}, 8'd3);
    // Random phase
    for (int i = 0; i < 5000; i++) begin
      ext_rst       = ($urandom % 64) == 0;
      sw_rst        = ($urandom % 64) == 0;
      wdt_rst       = ($urandom % 64) == 0;
      irq           = ($urandom % 8) == 0;
      clk_sel_main  = ($urandom % 4) != 0;
      sleep_req     = ($urandom % 4) == 0;
      stop_req      = ($urandom % 6) == 0;
      pin_float_sel = $urandom % 2;
      osc_stable    = ($urandom % 8) != 0;
      pll_stable    = ($urandom % 4) != 0;
      cyc();
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule